// File: doc/BRIEF.md
# Index-Mapping Ping-Pong Input Buffer

This block collects 8x8 blocks of 9-bit signed pixels, one word per cycle in raster order over row n1 and column n2, and hands each finished block to a distributed-arithmetic datapath as a bit-serial stream over all 64 words at once. Each pixel is written to word n1*8 + t. The column t comes from a modular index mapping that differs per row, so the direct two-dimensional transform downstream can use one-dimensional kernels without any further reordering.

Two storage banks alternate. One bank fills from the input stream while the other is emitted, one bit plane per cycle, least significant bit first, over nine cycles. The final plane carries a flag marking it as the sign plane so the consumer can subtract it. A bank swap takes place only when the filling bank holds a full block and the draining bank has emitted every plane. Until then the input is held off.

Top module: `index_map_pingpong_buf`

## Requirements
- R1: While rst_n is low and directly after it, in_ready is 1 and out_valid is 0.
- R2: A pixel is taken only on a clock edge where in_valid and in_ready are both 1. Cycles with in_valid low leave the block contents unchanged.
- R3: The k-th pixel accepted in a block (n1 = k/8, n2 = k mod 8) is stored in word n1*8 + t, where t in 0..7 is the unique value with (4t+1)(4n1+1) ≡ 4n2+1 (mod 32).
- R4: In the cycle after the 64th pixel of a block is accepted, in_ready is 0. It stays 0 until the bank swap.
- R5: When a block is full and the read side is idle, the swap happens on the next edge. In the cycle after the swap, out_valid is 1 with out_first set.
- R6: A block is read out over 9 consecutive cycles with out_bit_idx = 0..8. In the cycle with index j, out_bits[i] equals bit j of word i, two's complement.
- R7: out_first is 1 exactly on the plane with index 0. out_last, the sign-plane flag, is 1 exactly on index 8.
- R8: A new block is written into the other bank while the previous block is being read. The read data are unaffected by those writes.
- R9: A swap never happens while a read is in progress, except on its last plane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel is present |
| in_data | input | 9 | Signed pixel, two's complement |
| in_ready | output | 1 | Buffer can take a pixel |
| out_valid | output | 1 | A bit plane is presented |
| out_bits | output | 64 | Current bit of each of the 64 words |
| out_bit_idx | output | 4 | Index of the current bit plane, 0..8 |
| out_first | output | 1 | First plane of a block |
| out_last | output | 1 | Sign plane, last of a block |

## Verification
Writing the next block and reading the previous one fall in the same cycles. This is forced by streaming blocks back to back, so that every readout overlaps the first pixels of the following block in the other bank. Each reconstructed word is compared against the pixel the bench places there using its own search for t. A bench that computed the mapping the same way as the design could not catch a mapping error, so the search differs from the design's modular-inverse formula. One block is sent with idle gaps and one with ±255, 0 and -1, to cover ignored cycles and sign handling.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
  localparam int unsigned SIDE_DEF = 8;
  localparam int unsigned PIX_DEF  = 9;

  // Column t for row n1 and input column n2: solves
  // (4t+1)(4n1+1) == 4n2+1 mod 4*side by a modular inverse (Newton steps).
  function automatic logic [31:0] col_map(input logic [31:0] n1,
                                          input logic [31:0] n2,
                                          input logic [31:0] side);
    logic [31:0] a, x, v;
    a = 4 * n1 + 1;
    x = a;
    for (int i = 0; i < 4; i++) x = x * (32'd2 - a * x);
    v = ((4 * n2 + 1) * x) & (4 * side - 1);
    return v >> 2;
  endfunction
endpackage

// File: rtl/ibuf_addr_gen.sv
module ibuf_addr_gen #(
  parameter int unsigned SIDE = 8,
  localparam int unsigned SW  = $clog2(SIDE),
  localparam int unsigned AW  = 2 * SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  output logic [AW-1:0] wr_addr,
  output logic          last_acc
);
  import ibuf_pkg::*;
  logic [SW-1:0] row_q, col_q;
  logic [31:0]   t_full;

  assign t_full   = col_map(32'(row_q), 32'(col_q), 32'(SIDE));
  assign wr_addr  = {row_q, t_full[SW-1:0]};
  assign last_acc = accept && (row_q == SW'(SIDE-1)) && (col_q == SW'(SIDE-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (accept) begin
      col_q <= col_q + 1'b1;
      if (col_q == SW'(SIDE-1)) row_q <= row_q + 1'b1;
    end
  end
endmodule

// File: rtl/ibuf_ctrl.sv
module ibuf_ctrl #(
  parameter int unsigned PIX = 9,
  localparam int unsigned BW = $clog2(PIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          last_acc,
  output logic          wr_full,
  output logic          wr_bank,
  output logic          rd_busy,
  output logic [BW-1:0] bit_idx,
  output logic          swap_evt
);
  logic rd_last;
  assign rd_last  = rd_busy && (bit_idx == BW'(PIX-1));
  assign swap_evt = wr_full && (!rd_busy || rd_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_full <= 1'b0;
      wr_bank <= 1'b0;
      rd_busy <= 1'b0;
      bit_idx <= '0;
    end else begin
      if (last_acc)      wr_full <= 1'b1;
      else if (swap_evt) wr_full <= 1'b0;
      if (swap_evt) begin
        wr_bank <= ~wr_bank;
        rd_busy <= 1'b1;
        bit_idx <= '0;
      end else if (rd_busy) begin
        if (rd_last) begin
          rd_busy <= 1'b0;
          bit_idx <= '0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ibuf_bank_pair.sv
module ibuf_bank_pair #(
  parameter int unsigned WORDS = 64,
  parameter int unsigned PIX   = 9,
  localparam int unsigned AW   = $clog2(WORDS),
  localparam int unsigned BW   = $clog2(PIX)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             wr_bank,
  input  logic [AW-1:0]    wr_addr,
  input  logic [PIX-1:0]   wr_data,
  input  logic             rd_bank,
  input  logic [BW-1:0]    bit_idx,
  output logic [WORDS-1:0] slice
);
  logic [PIX-1:0] mem [2][WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[wr_bank][wr_addr] <= wr_data;
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_slice
    assign slice[i] = mem[rd_bank][i][bit_idx];
  end
endmodule

// File: rtl/index_map_pingpong_buf.sv
module index_map_pingpong_buf #(
  parameter int unsigned SIDE = 8,
  parameter int unsigned PIX  = 9,
  localparam int unsigned WORDS = SIDE * SIDE,
  localparam int unsigned AW    = $clog2(WORDS),
  localparam int unsigned BW    = $clog2(PIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX-1:0]   in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [WORDS-1:0] out_bits,
  output logic [BW-1:0]    out_bit_idx,
  output logic             out_first,
  output logic             out_last
);
  logic          accept, last_acc, wr_full, wr_bank, rd_busy, swap_evt;
  logic [AW-1:0] wr_addr;
  logic [BW-1:0] bit_idx;

  assign in_ready = !wr_full;
  assign accept   = in_valid && in_ready;

  ibuf_addr_gen #(.SIDE(SIDE)) u_addr (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .wr_addr(wr_addr), .last_acc(last_acc)
  );

  ibuf_ctrl #(.PIX(PIX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .last_acc(last_acc),
    .wr_full(wr_full), .wr_bank(wr_bank), .rd_busy(rd_busy),
    .bit_idx(bit_idx), .swap_evt(swap_evt)
  );

  ibuf_bank_pair #(.WORDS(WORDS), .PIX(PIX)) u_banks (
    .clk(clk), .we(accept), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(in_data), .rd_bank(~wr_bank), .bit_idx(bit_idx),
    .slice(out_bits)
  );

  assign out_valid   = rd_busy;
  assign out_bit_idx = bit_idx;
  assign out_first   = rd_busy && (bit_idx == '0);
  assign out_last    = rd_busy && (bit_idx == BW'(PIX-1));
endmodule

// File: rtl/ibuf_chk.sv
module ibuf_chk #(
  parameter int unsigned WORDS = 64,
  parameter int unsigned PIX   = 9,
  localparam int unsigned AW   = $clog2(WORDS),
  localparam int unsigned BW   = $clog2(PIX)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [BW-1:0] out_bit_idx,
  input logic          out_first,
  input logic          out_last,
  input logic          swap_evt
);
  logic [AW-1:0] acc_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_cnt <= '0;
    else if (in_valid && in_ready) acc_cnt <= acc_cnt + 1'b1;
  end

  // R4
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && acc_cnt == AW'(WORDS-1)) |=> !in_ready);
  // R5
  swap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> (out_valid && out_first));
  // R9
  swap_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |-> (!out_valid || out_last));
  // R6
  plane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> (out_valid && out_bit_idx == BW'($past(out_bit_idx) + 1'b1)));
  // R7
  first_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(out_valid)) |-> out_first);
  // R7
  after_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> (!out_valid || out_first));
endmodule

bind index_map_pingpong_buf ibuf_chk #(.WORDS(WORDS), .PIX(PIX)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_bit_idx(out_bit_idx), .out_first(out_first),
  .out_last(out_last), .swap_evt(swap_evt)
);

// File: tb/index_map_pingpong_buf_tb.sv
`timescale 1ns/1ps
module index_map_pingpong_buf_tb;
  localparam int NBLK = 6;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [8:0]  in_data = '0;
  logic        in_ready, out_valid, out_first, out_last;
  logic [63:0] out_bits;
  logic [3:0]  out_bit_idx;

  int checks = 0, fails = 0, blk_rd = 0, plane = 0;
  bit done = 0;
  logic [8:0] exp_mem [NBLK][64];
  logic [8:0] got [64];

  always #2.5 clk = ~clk;

  index_map_pingpong_buf u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int find_t(input int n1, input int n2);
    for (int t = 0; t < 8; t++)
      if ((((4 * t + 1) * (4 * n1 + 1)) % 32) == 4 * n2 + 1) return t;
    return -1;
  endfunction

  function automatic int pix(input int b, input int k);
    case (b)
      0: return k * 4 - 128;
      1: return (k % 4 == 0) ? 255 : (k % 4 == 1) ? -255 : (k % 4 == 2) ? -1 : 0;
      2: return ((k * 97 + 31) * 53) % 511 - 255;
      3: return k * 3 - 100;
      4: return 100 - k * 5;
      default: return -(k * 4);
    endcase
  endfunction

  task automatic push(input logic [8:0] v);
    in_valid = 1'b1;
    in_data  = v;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: rebuild words from bit planes, compare each block (R3, R6, R8)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      chk(out_bit_idx == 4'(plane), "R6 plane index", out_bit_idx, plane);
      chk(out_first == (plane == 0), "R7 out_first", out_first, plane == 0);
      chk(out_last == (plane == 8), "R7 out_last", out_last, plane == 8);
      for (int i = 0; i < 64; i++) got[i][plane] = out_bits[i];
      if (plane == 8) begin
        for (int i = 0; i < 64; i++)
          chk(blk_rd < NBLK && got[i] == exp_mem[blk_rd][i], "R3/R6/R8 word",
              $signed(got[i]), blk_rd < NBLK ? $signed(exp_mem[blk_rd][i]) : 0);
        blk_rd++;
        plane = 0;
      end else plane++;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R1 after reset", {in_ready, out_valid}, 2);
    for (int b = 0; b < NBLK; b++) begin
      for (int k = 0; k < 64; k++) begin
        int v, t;
        v = pix(b, k);
        t = find_t(k / 8, k % 8);
        exp_mem[b][(k / 8) * 8 + t] = 9'(v);
        if (b == 3 && k % 3 == 0) begin   // R2 idle gaps with junk data
          in_valid = 1'b0;
          in_data  = 9'h155;
          repeat (2) @(negedge clk);
        end
        push(9'(v));
      end
      in_valid = 1'b0;
      chk(in_ready == 1'b0, "R4 ready low after 64th", in_ready, 0);
      @(negedge clk);
      chk(out_valid && out_first, "R5 read starts after swap", {out_valid, out_first}, 3);
      chk(in_ready == 1'b1, "R4 ready back after swap", in_ready, 1);
    end
    repeat (20) @(negedge clk);
    chk(blk_rd == NBLK, "R8 all blocks read", blk_rd, NBLK);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule